// File: doc/BRIEF.md
# Single Stuck-At Fault Injection Tester

This block is a built-in self-test harness around a small three-input logic cone, f = x1·x2 + x3, built from one AND gate and one OR gate. Five nets of the cone are numbered. Nets 1, 2 and 3 are the inputs x1, x2 and x3. Net 4 is the AND output and net 5 is the OR output. A fault-select code can tie any one of these nets to 0 or to 1, or it can leave the cone intact.

A start pulse launches a four-step sequence that drives one stored test vector into the cone per clock cycle. Each step compares the cone's response with the fault-free response, which the block holds in a constant table. A mismatch on step i sets bit i of a 4-bit signature. When the sequence ends, a one-cycle done pulse marks the result as valid. The fail flag then shows whether any step mismatched. The four vectors form a minimal set that exposes all ten single stuck-at faults. The signature pattern also groups the faults into classes that share the same faulty function.

Top module: `stuck_fault_tester`

## Requirements
- R1: While rst_n is low and after its release, busy, done, fail and the signature are all 0, and test_vec is 000.
- R2: The fault code selects as follows. 0 means no fault. Code 2k-1 ties net k to 0 and code 2k ties net k to 1, for k = 1..5. Codes 11 to 15 act as no fault.
- R3: After start is accepted, test_vec (bit 2 = x1, bit 1 = x2, bit 0 = x3) carries 110, 010, 011 and 100 on four consecutive cycles. cut_resp shows the cone's output under the selected fault for the vector on test_vec.
- R4: The fault-free responses to the four vectors are 1, 0, 1 and 0. Signature bit i is set exactly when the response to vector i differs from its fault-free value.
- R5: fail equals the OR of the four signature bits.
- R6: busy is high for exactly four cycles. done is high for exactly one cycle, in the cycle that follows the last comparison, with busy low.
- R7: A start pulse while busy is high is ignored. The running sequence neither restarts nor lengthens.
- R8: The fault code is captured in the cycle start is accepted. Changes to fault_sel during a sequence have no effect on that sequence.
- R9: Every code from 1 to 10 produces a nonzero signature. Codes 0 and 11 to 15 produce 0000.
- R10: The signature is cleared when start is accepted. After done it holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | One-cycle pulse that launches a test sequence |
| fault_sel | input | 4 | Fault injection code, captured at start |
| busy | output | 1 | High while the four vectors are applied |
| done | output | 1 | One-cycle pulse after the last comparison |
| fail | output | 1 | OR of the signature bits |
| signature | output | 4 | Per-vector mismatch flags, bit i for vector i |
| test_vec | output | 3 | Vector currently driven into the cone, 000 when idle |
| cut_resp | output | 1 | Cone output under the selected fault |

## Verification
The bench sweeps all sixteen fault codes. For each code it computes the expected per-step response from a net-level model of the cone and derives the expected signature from it. The fault-free code and the five unused codes must give an all-zero signature. Each real fault must give the signature of its class: 0001 for the nets that collapse the output to x3, 0010 for x2+x3, 1000 for x1+x3, 0100 for x1·x2, 1010 for constant 1 and 0101 for constant 0. During every run the bench changes fault_sel after launch, and in a separate run it pulses start mid-sequence, so that a design that resamples either input shows a wrong signature or a wrong timing.

// File: rtl/stf_pkg.sv
package stf_pkg;

  localparam int unsigned NUM_IN    = 3;
  localparam int unsigned NUM_WIRES = 5;
  localparam int unsigned NUM_VEC   = 4;
  localparam int unsigned CODE_W    = 4;
  localparam int unsigned IDX_W     = $clog2(NUM_VEC);

  // bit 2 = x1, bit 1 = x2, bit 0 = x3
  typedef logic [NUM_IN-1:0] vec_t;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'b00,
    SEQ_RUN  = 2'b01
  } seq_state_e;

  // Ordered minimal test set; order fixes the signature bit positions.
  function automatic vec_t test_vector(input logic [IDX_W-1:0] idx);
    vec_t v;
    case (idx)
      IDX_W'(0): v = 3'b110;
      IDX_W'(1): v = 3'b010;
      IDX_W'(2): v = 3'b011;
      default:   v = 3'b100;
    endcase
    return v;
  endfunction

  // Intact cone response.
  function automatic logic fault_free(input vec_t v);
    return (v[2] & v[1]) | v[0];
  endfunction

endpackage

// File: rtl/stf_injector.sv
module stf_injector
  import stf_pkg::*;
#(
  parameter int unsigned N_WIRES = NUM_WIRES,
  parameter int unsigned SEL_W   = CODE_W
) (
  input  logic [SEL_W-1:0]   code,
  output logic [N_WIRES-1:0] force_en,
  output logic [N_WIRES-1:0] force_val
);

  // Net k (1-based) = index k-1: tie-low code 2k-1, tie-high code 2k.
  for (genvar w = 0; w < N_WIRES; w++) begin : g_net
    localparam logic [SEL_W-1:0] CODE_LO = SEL_W'(2 * w + 1);
    localparam logic [SEL_W-1:0] CODE_HI = SEL_W'(2 * w + 2);

    logic hit_lo;
    logic hit_hi;

    assign hit_lo       = (code == CODE_LO);
    assign hit_hi       = (code == CODE_HI);
    assign force_en[w]  = hit_lo | hit_hi;
    assign force_val[w] = hit_hi;
  end

endmodule

// File: rtl/stf_cut.sv
module stf_cut
  import stf_pkg::*;
(
  input  vec_t                 x,
  input  logic [NUM_WIRES-1:0] force_en,
  input  logic [NUM_WIRES-1:0] force_val,
  output logic                 f
);

  localparam int unsigned NET_AND = NUM_IN;
  localparam int unsigned NET_OR  = NUM_IN + 1;

  logic [NUM_IN-1:0] in_net;
  logic              and_raw;
  logic              and_net;
  logic              or_raw;
  logic              or_net;

  // Input nets 1..3 map to x1, x2, x3 (vector bits 2, 1, 0).
  for (genvar i = 0; i < NUM_IN; i++) begin : g_in
    assign in_net[i] = force_en[i] ? force_val[i] : x[NUM_IN-1-i];
  end

  assign and_raw = in_net[0] & in_net[1];
  assign and_net = force_en[NET_AND] ? force_val[NET_AND] : and_raw;
  assign or_raw  = and_net | in_net[2];
  assign or_net  = force_en[NET_OR] ? force_val[NET_OR] : or_raw;
  assign f       = or_net;

endmodule

// File: rtl/stf_sequencer.sv
module stf_sequencer
  import stf_pkg::*;
#(
  parameter int unsigned STEPS = NUM_VEC,
  localparam int unsigned SW   = $clog2(STEPS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          launch,
  output logic          busy,
  output logic [SW-1:0] step_idx,
  output logic          done
);

  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  seq_state_e    state_q, state_d;
  logic [SW-1:0] idx_q, idx_d;
  logic          done_q, done_d;

  assign launch = start & (state_q == SEQ_IDLE);

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    done_d  = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RUN;
          idx_d   = '0;
        end
      end
      SEQ_RUN: begin
        if (idx_q == LAST) begin
          state_d = SEQ_IDLE;
          idx_d   = '0;
          done_d  = 1'b1;
        end else begin
          idx_d = idx_q + SW'(1);
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      done_q  <= done_d;
    end
  end

  assign busy     = (state_q == SEQ_RUN);
  assign step_idx = idx_q;
  assign done     = done_q;

endmodule

// File: rtl/stf_signature.sv
module stf_signature
  import stf_pkg::*;
#(
  parameter int unsigned STEPS = NUM_VEC,
  localparam int unsigned SW   = $clog2(STEPS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             step_valid,
  input  logic [SW-1:0]    step_idx,
  input  logic             mismatch,
  output logic [STEPS-1:0] sig
);

  for (genvar b = 0; b < STEPS; b++) begin : g_bit
    logic set_en;
    logic bit_en;
    logic bit_d;
    logic bit_q;

    assign set_en = step_valid & (step_idx == SW'(b));
    assign bit_en = clear | set_en;
    assign bit_d  = clear ? 1'b0 : mismatch;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else if (bit_en) begin
        bit_q <= bit_d;
      end
    end

    assign sig[b] = bit_q;
  end

endmodule

// File: rtl/stuck_fault_tester.sv
module stuck_fault_tester
  import stf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] fault_sel,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [NUM_VEC-1:0] signature,
  output logic [NUM_IN-1:0] test_vec,
  output logic              cut_resp
);

  logic                 launch;
  logic [IDX_W-1:0]     step_idx;
  logic [CODE_W-1:0]    fault_q;
  logic [NUM_WIRES-1:0] force_en;
  logic [NUM_WIRES-1:0] force_val;
  logic [NUM_VEC-1:0]   golden_tbl;
  vec_t                 vec_cur;
  logic                 resp;
  logic                 mismatch;

  // Fault code register, loaded only on an accepted start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault_q <= '0;
    end else if (launch) begin
      fault_q <= fault_sel;
    end
  end

  stf_sequencer #(.STEPS(NUM_VEC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .launch   (launch),
    .busy     (busy),
    .step_idx (step_idx),
    .done     (done)
  );

  stf_injector #(.N_WIRES(NUM_WIRES), .SEL_W(CODE_W)) u_inj (
    .code      (fault_q),
    .force_en  (force_en),
    .force_val (force_val)
  );

  // Fault-free response table derived from the stored vectors.
  for (genvar g = 0; g < NUM_VEC; g++) begin : g_gold
    assign golden_tbl[g] = fault_free(test_vector(IDX_W'(g)));
  end

  assign vec_cur = busy ? test_vector(step_idx) : '0;

  stf_cut u_cut (
    .x         (vec_cur),
    .force_en  (force_en),
    .force_val (force_val),
    .f         (resp)
  );

  assign mismatch = resp ^ golden_tbl[step_idx];

  stf_signature #(.STEPS(NUM_VEC)) u_sig (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (launch),
    .step_valid (busy),
    .step_idx   (step_idx),
    .mismatch   (mismatch),
    .sig        (signature)
  );

  assign fail     = |signature;
  assign test_vec = vec_cur;
  assign cut_resp = resp;

endmodule

// File: rtl/stf_checker.sv
module stf_checker
  import stf_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               busy,
  input logic               done,
  input logic               fail,
  input logic [NUM_VEC-1:0] signature,
  input logic [NUM_IN-1:0]  test_vec,
  input logic [CODE_W-1:0]  fault_q
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6

  AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R6

  AST_SIG_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(signature)); // R10

  AST_VEC_IN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (test_vec == 3'b110 || test_vec == 3'b010 ||
              test_vec == 3'b011 || test_vec == 3'b100)); // R3

  AST_CLEAN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (fault_q == 4'd0 || fault_q > 4'd10)) |-> !fail); // R9

  AST_FAULT_CAUGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault_q >= 4'd1 && fault_q <= 4'd10) |-> (signature != '0)); // R9

  AST_CODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(fault_q)); // R8

endmodule

bind stuck_fault_tester stf_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .fail      (fail),
  .signature (signature),
  .test_vec  (test_vec),
  .fault_q   (fault_q)
);

// File: tb/tb_stuck_fault_tester.sv
`timescale 1ns/1ps
module tb_stuck_fault_tester;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic [3:0] fault_sel;
  logic       busy;
  logic       done;
  logic       fail;
  logic [3:0] signature;
  logic [2:0] test_vec;
  logic       cut_resp;

  int checks;
  int fails;

  stuck_fault_tester dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .fault_sel (fault_sel),
    .busy      (busy),
    .done      (done),
    .fail      (fail),
    .signature (signature),
    .test_vec  (test_vec),
    .cut_resp  (cut_resp)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [2:0] exp_vec(input int i);
    case (i)
      0: return 3'b110;
      1: return 3'b010;
      2: return 3'b011;
      default: return 3'b100;
    endcase
  endfunction

  // Net-level model of the cone under fault code c (R2).
  function automatic logic model_f(input int c, input logic [2:0] v);
    int   net;
    logic val;
    logic n1, n2, n3, n4, n5;
    net = (c >= 1 && c <= 10) ? (c + 1) / 2 : 0;
    val = (c % 2 == 0);
    n1 = (net == 1) ? val : v[2];
    n2 = (net == 2) ? val : v[1];
    n3 = (net == 3) ? val : v[0];
    n4 = (net == 4) ? val : (n1 & n2);
    n5 = (net == 5) ? val : (n4 | n3);
    return n5;
  endfunction

  function automatic logic [3:0] exp_sig(input int c);
    logic [3:0] s;
    for (int i = 0; i < 4; i++) begin
      s[i] = model_f(c, exp_vec(i)) ^ model_f(0, exp_vec(i));
    end
    return s;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Launch with code c; after launch drive fault_sel with a different code (R8).
  // Optionally pulse start mid-run (R7).
  task automatic run_seq(input int c, input bit poke_start);
    logic [3:0] es;
    es = exp_sig(c);
    @(negedge clk);
    fault_sel = 4'(c);
    start     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start     = 1'b0;
    fault_sel = 4'(c) ^ 4'hA;
    check(signature == 4'h0, "R10", "signature cleared on launch", signature, 0);
    for (int i = 0; i < 4; i++) begin
      if (i > 0) @(negedge clk);
      check(busy == 1'b1, "R6", "busy during step", busy, 1);
      check(test_vec == exp_vec(i), "R3", "vector order", test_vec, exp_vec(i));
      check(cut_resp == model_f(c, exp_vec(i)), "R2", "faulted response",
            cut_resp, model_f(c, exp_vec(i)));
      if (poke_start && i == 1) start = 1'b1;
      if (poke_start && i == 2) start = 1'b0;
    end
    @(negedge clk);
    check(done == 1'b1 && busy == 1'b0, "R6", "done pulse after four steps",
          {done, busy}, 2'b10);
    check(signature == es, "R4", $sformatf("signature code %0d", c), signature, es);
    check(fail == (es != 0), "R5", "fail flag", fail, (es != 0));
    if (c >= 1 && c <= 10)
      check(signature != 4'h0, "R9", "real fault detected", signature, es);
    else
      check(signature == 4'h0, "R9", "no-fault code passes", signature, 0);
    @(negedge clk);
    check(done == 1'b0 && busy == 1'b0, "R7", "single done, no restart",
          {done, busy}, 2'b00);
    check(signature == es, "R10", "signature held after done", signature, es);
  endtask

  initial begin
    checks    = 0;
    fails     = 0;
    rst_n     = 1'b0;
    start     = 1'b0;
    fault_sel = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check({busy, done, fail, signature, test_vec} == '0, "R1",
          "outputs in reset", {busy, done, fail, signature, test_vec}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check({busy, done, fail, signature, test_vec} == '0, "R1",
          "outputs after reset", {busy, done, fail, signature, test_vec}, 0);

    for (int c = 0; c < 16; c++) begin
      run_seq(c, 1'b0);
    end
    // Mid-run start must be ignored (R7).
    run_seq(9, 1'b1);
    run_seq(0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule